// File: doc/BRIEF.md
# Paired-Instruction Fetch Unit

This block is the fetch side of the instruction cycle for a simple accumulator machine whose memory words are 40 bits wide and carry two 20-bit instructions each. An instruction is an 8-bit opcode in its upper bits and a 12-bit operand address in its lower bits. The unit reads one word at a time from a synchronous memory with one cycle of read latency. It captures the word in a memory buffer register and places the left-hand instruction in an opcode register and an operand-address register. The right-hand instruction is parked in a holding register, so the following fetch takes it from there without touching memory.

Each decoded instruction is offered to an execute stage with a valid/ready handshake. It stays in the output registers, and fetching stalls, until the execute stage accepts it. The program counter names the next word, not the next instruction, and it advances only when a word is read. A redirect input loads a new program counter value and discards both the buffered half and any instruction on offer. The memory holds 1000 words. A program counter beyond the last word raises an address-error flag, and no read is issued while the flag is set.

Top module: `pair_fetch`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid` and `addr_err` are 0. The program counter restarts at word 0, and the first memory read after reset is at address 0.
- R2: From a word, the left-hand instruction (opcode in bits 39:32, operand address in bits 31:20) is delivered before the right-hand instruction (opcode in bits 19:12, operand address in bits 11:0).
- R3: When a right-hand instruction is held, the next fetch delivers it without a memory read, and `mem_rd_en` stays 0 while the holding register is full.
- R4: Every memory read advances the program counter by exactly one, so that successive reads without a redirect go to consecutive addresses. Delivering a held right-hand instruction does not advance it.
- R5: While `out_valid` is 1 and `out_ready` is 0 (no redirect), `out_valid`, `out_opcode` and `out_addr` hold their values and no memory read is issued.
- R6: A one-cycle `redir_valid` pulse loads `redir_target` into the program counter. It drops any offered instruction and empties the holding register, so the next delivered instruction is the left-hand half of the target word.
- R7: When the program counter exceeds 999, `addr_err` is 1 and no memory read is issued until a redirect to a legal word clears the condition.
- R8: Read data is taken from `mem_rdata` in the cycle after `mem_rd_en`, and the memory is never asked for two reads in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_en | output | 1 | Read strobe to the synchronous memory |
| mem_addr | output | 12 | Word address of the read (program counter) |
| mem_rdata | input | 40 | Word returned one cycle after the strobe |
| redir_valid | input | 1 | Jump redirect pulse |
| redir_target | input | 12 | New program counter value for a redirect |
| out_valid | output | 1 | An instruction is offered to the execute stage |
| out_ready | input | 1 | Execute stage accepts the offered instruction |
| out_opcode | output | 8 | Opcode register contents |
| out_addr | output | 12 | Operand-address register contents |
| addr_err | output | 1 | Program counter is beyond the last memory word |

## Verification
A holding register whose valid flag is wrong shows up at the ports within one fetch. If the flag is stuck clear, an extra memory read appears and the right-hand instruction is skipped. If it is stuck set, a stale instruction comes out after a redirect instead of the target's left half. A program counter that steps at the wrong time shows up on `mem_addr` at the very next read, and a broken stall shows up as a changed opcode or address while ready is low. The directed scenarios count memory reads independently and compare every delivered instruction with the word contents, so each of these faults shows up at the next handshake.

// File: rtl/pairfetch_pkg.sv
package pairfetch_pkg;

    localparam int OPC_W  = 8;
    localparam int FLD_W  = 12;
    localparam int INS_W  = OPC_W + FLD_W;
    localparam int WORD_W = 2 * INS_W;

    typedef struct packed {
        logic [OPC_W-1:0] opc;
        logic [FLD_W-1:0] fld;
    } instr_t;

    typedef enum logic [1:0] {
        ST_ISSUE   = 2'd0,
        ST_WAIT    = 2'd1,
        ST_SPLIT   = 2'd2,
        ST_PRESENT = 2'd3
    } fetch_st_e;

    // The upper half of a word runs first.
    function automatic instr_t first_half(input logic [WORD_W-1:0] w);
        return instr_t'(w[WORD_W-1:INS_W]);
    endfunction

    function automatic instr_t second_half(input logic [WORD_W-1:0] w);
        return instr_t'(w[INS_W-1:0]);
    endfunction

endpackage

// File: rtl/pf_pc_reg.sv
module pf_pc_reg #(
    parameter int AW      = 12,
    parameter int N_WORDS = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] pc,
    output logic          out_of_range
);
    localparam logic [AW-1:0] LAST_WORD = AW'(N_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (load) pc <= load_val;
        else if (step) pc <= pc + 1'b1;
    end

    assign out_of_range = (pc > LAST_WORD);

endmodule

// File: rtl/pf_hold_buf.sv
module pf_hold_buf
    import pairfetch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flush,
    input  logic   fill,
    input  instr_t fill_val,
    input  logic   drain,
    output logic   valid,
    output instr_t held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            held  <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (fill) begin
            valid <= 1'b1;
            held  <= fill_val;
        end else if (drain) begin
            valid <= 1'b0;
        end
    end

    // R3: a new right half never overwrites one still pending
    a_r3_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        fill |-> !valid);

    // R3: a drain only happens with something held
    a_r3_drain_when_full: assert property (@(posedge clk) disable iff (rst)
        drain |-> valid);

endmodule

// File: rtl/pair_fetch.sv
module pair_fetch
    import pairfetch_pkg::*;
#(
    parameter int AW      = FLD_W,
    parameter int N_WORDS = 1000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              redir_valid,
    input  logic [AW-1:0]     redir_target,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OPC_W-1:0]  out_opcode,
    output logic [FLD_W-1:0]  out_addr,
    output logic              addr_err
);
    fetch_st_e         state;
    logic [WORD_W-1:0] mbr;
    logic [OPC_W-1:0]  ir;
    logic [FLD_W-1:0]  mar;
    logic              ovalid;
    logic [AW-1:0]     pc;
    logic              pc_bad;
    logic              buf_valid;
    instr_t            buf_held;
    logic              buf_fill;
    logic              buf_drain;

    pf_pc_reg #(.AW(AW), .N_WORDS(N_WORDS)) u_pc (
        .clk          (clk),
        .rst          (rst),
        .step         (mem_rd_en),
        .load         (redir_valid),
        .load_val     (redir_target),
        .pc           (pc),
        .out_of_range (pc_bad)
    );

    pf_hold_buf u_buf (
        .clk      (clk),
        .rst      (rst),
        .flush    (redir_valid),
        .fill     (buf_fill),
        .fill_val (second_half(mbr)),
        .drain    (buf_drain),
        .valid    (buf_valid),
        .held     (buf_held)
    );

    assign mem_rd_en = !rst && (state == ST_ISSUE) && !buf_valid && !pc_bad && !redir_valid;
    assign mem_addr  = pc;
    assign buf_fill  = (state == ST_SPLIT) && !redir_valid;
    assign buf_drain = (state == ST_ISSUE) && buf_valid && !redir_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_ISSUE;
            ovalid <= 1'b0;
            ir     <= '0;
            mar    <= '0;
            mbr    <= '0;
        end else if (redir_valid) begin
            state  <= ST_ISSUE;
            ovalid <= 1'b0;
        end else begin
            unique case (state)
                ST_ISSUE: begin
                    if (buf_valid) begin
                        ir     <= buf_held.opc;
                        mar    <= buf_held.fld;
                        ovalid <= 1'b1;
                        state  <= ST_PRESENT;
                    end else if (mem_rd_en) begin
                        state  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    mbr   <= mem_rdata;
                    state <= ST_SPLIT;
                end
                ST_SPLIT: begin
                    ir     <= first_half(mbr).opc;
                    mar    <= first_half(mbr).fld;
                    ovalid <= 1'b1;
                    state  <= ST_PRESENT;
                end
                ST_PRESENT: begin
                    if (out_ready) begin
                        ovalid <= 1'b0;
                        state  <= ST_ISSUE;
                    end
                end
                default: state <= ST_ISSUE;
            endcase
        end
    end

    assign out_valid  = ovalid;
    assign out_opcode = ir;
    assign out_addr   = mar;
    assign addr_err   = pc_bad;

    // R5: an offered instruction is held until accepted
    a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !redir_valid |=>
            out_valid && $stable(out_opcode) && $stable(out_addr));

    // R5: no read while an instruction waits
    a_r5_no_read_while_offered: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mem_rd_en);

    // R3: a held half blocks memory access
    a_r3_buf_blocks_read: assert property (@(posedge clk) disable iff (rst)
        buf_valid |-> !mem_rd_en);

    // R4: each read advances the word address by one
    a_r4_pc_advance: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en && !redir_valid |=> mem_addr == $past(mem_addr) + 1'b1);

    // R6: redirect loads the target and drops the offer
    a_r6_redirect: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (mem_addr == $past(redir_target)) && !out_valid);

    // R7: no read while out of range
    a_r7_no_read_in_err: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> !mem_rd_en);

    // R8: one read in flight at most
    a_r8_single_read: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en);

endmodule

// File: tb/pair_fetch_tb.sv
module pair_fetch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [39:0] mem_rdata = '0;
    logic        redir_valid = 1'b0;
    logic [11:0] redir_target = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_opcode;
    logic [11:0] out_addr;
    logic        addr_err;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    logic [11:0] last_rd = '0;
    logic done = 1'b0;

    logic [39:0] mem [0:1023];

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_fetch u_dut (
        .clk          (clk),
        .rst          (rst),
        .mem_rd_en    (mem_rd_en),
        .mem_addr     (mem_addr),
        .mem_rdata    (mem_rdata),
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_opcode   (out_opcode),
        .out_addr     (out_addr),
        .addr_err     (addr_err)
    );

    function automatic logic [7:0]  op_l(int i); return 8'(i * 3 + 1);  endfunction
    function automatic logic [11:0] ad_l(int i); return 12'(i + 100);   endfunction
    function automatic logic [7:0]  op_r(int i); return 8'(i * 5 + 7);  endfunction
    function automatic logic [11:0] ad_r(int i); return 12'(1023 - i);  endfunction

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = {op_l(i), ad_l(i), op_r(i), ad_r(i)};
    end

    // synchronous memory, one cycle latency, plus an independent read counter
    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (!rst && mem_rd_en) begin
            rd_cnt  <= rd_cnt + 1;
            last_rd <= mem_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic take(input logic [7:0] eop, input logic [11:0] ead, input string tag);
        int n = 0;
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(out_valid, {tag, " valid"}, longint'(out_valid), 1);
        chk(out_opcode == eop, {tag, " opcode"}, longint'(out_opcode), longint'(eop));
        chk(out_addr == ead, {tag, " addr"}, longint'(out_addr), longint'(ead));
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic redirect(input logic [11:0] tgt);
        redir_valid  = 1'b1;
        redir_target = tgt;
        @(negedge clk);
        redir_valid  = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        chk(addr_err == 1'b0, "R1 addr_err in reset", longint'(addr_err), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    endtask

    task automatic t_pairs;
        take(op_l(0), ad_l(0), "R2 R8 word0 left");
        chk(rd_cnt == 1, "R1 one read", rd_cnt, 1);
        chk(last_rd == 12'd0, "R1 first read at 0", longint'(last_rd), 0);
        take(op_r(0), ad_r(0), "R2 word0 right");
        chk(rd_cnt == 1, "R3 right half no read", rd_cnt, 1);
        take(op_l(1), ad_l(1), "R2 word1 left");
        chk(rd_cnt == 2, "R4 second read", rd_cnt, 2);
        chk(last_rd == 12'd1, "R4 consecutive address", longint'(last_rd), 1);
    endtask

    task automatic t_stall;
        logic [7:0] op0;
        logic [11:0] ad0;
        int r0;
        int n = 0;
        while (!out_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        op0 = out_opcode;
        ad0 = out_addr;
        r0  = rd_cnt;
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b1, "R5 valid held", longint'(out_valid), 1);
        chk(out_opcode == op0 && out_addr == ad0, "R5 data held",
            longint'({out_opcode, out_addr}), longint'({op0, ad0}));
        chk(rd_cnt == r0, "R5 no read in stall", rd_cnt, r0);
        take(op_r(1), ad_r(1), "R5 word1 right after stall");
        take(op_l(2), ad_l(2), "R4 word2 left");
        chk(last_rd == 12'd2, "R4 address 2", longint'(last_rd), 2);
    endtask

    task automatic t_redirect;
        // an instruction (word2 right) is offered and discarded
        repeat (2) @(negedge clk);
        redirect(12'd500);
        take(op_l(500), ad_l(500), "R6 target left");
        chk(last_rd == 12'd500, "R6 read at target", longint'(last_rd), 500);
        // right half of 500 is held; redirect must drop it
        redirect(12'd10);
        take(op_l(10), ad_l(10), "R6 buffer flushed");
        chk(last_rd == 12'd10, "R6 read at second target", longint'(last_rd), 10);
        take(op_r(10), ad_r(10), "R6 right after redirect");
    endtask

    task automatic t_range;
        int r0;
        redirect(12'd999);
        take(op_l(999), ad_l(999), "R7 last word left");
        take(op_r(999), ad_r(999), "R7 last word right");
        repeat (2) @(negedge clk);
        chk(addr_err == 1'b1, "R7 error past end", longint'(addr_err), 1);
        r0 = rd_cnt;
        repeat (10) @(negedge clk);
        chk(rd_cnt == r0, "R7 no read in error", rd_cnt, r0);
        chk(out_valid == 1'b0, "R7 nothing offered", longint'(out_valid), 0);
        redirect(12'd1005);
        chk(addr_err == 1'b1, "R7 error on far target", longint'(addr_err), 1);
        redirect(12'd3);
        chk(addr_err == 1'b0, "R7 error cleared", longint'(addr_err), 0);
        take(op_l(3), ad_l(3), "R7 resume at 3");
    endtask

    initial begin
        t_reset();
        t_pairs();
        t_stall();
        t_redirect();
        t_range();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule